// File: doc/BRIEF.md
# Priority Bus Arbiter with Locking

This block decides which of several bus masters owns a shared on-chip processor bus. Each master presents a request, a 2-bit priority that can change at run time, a burst mode with a beat count, a terminate strobe and a lock strobe. The slave side reports each completed data beat on a single transfer-done input. The arbiter drives a registered one-hot grant vector.

A transfer is a burst of one or more beats. The next owner is chosen during the final beat of the current burst, so the new grant takes effect on the very next clock and no idle cycle separates two owners. A master that holds its lock strobe during its final beat keeps the bus for another burst. Requests from all other masters are ignored until the locking master releases the lock and finishes a burst. Among requesters of equal priority, service rotates round-robin. The rotation starts just after the master granted most recently.

Top module: `prio_lock_arbiter`

## Requirements
- R1: While reset is held, and on the first cycle after it, the grant vector is all zero.
- R2: With no master owning the bus, a request sampled on a clock edge produces a grant on that same edge, so the grant is visible one cycle after the request is presented.
- R3: Among requesting masters the one with the numerically largest 2-bit priority is granted (3 is highest, 0 lowest).
- R4: Among requesting masters that tie at the largest priority, the first one found is granted. The search runs in ascending index order with wrap-around, starting at the index just above the master granted most recently. This pointer starts at index 0 after reset.
- R5: At most one grant bit is ever set.
- R6: In fixed mode (mode bit = 1) a burst lasts exactly length field + 1 beats. The length field is captured when the grant is issued. Only cycles with transfer-done high count as beats, and the grant is held until the last beat.
- R7: In variable mode (mode bit = 0) a burst ends on the first beat where the owner's terminate strobe is high together with transfer-done. A terminate strobe without transfer-done has no effect.
- R8: On the final beat of a burst the next owner is decided from the requests present in that cycle, and its grant appears on the following clock with no idle cycle.
- R9: If the owner's lock strobe is high on its final beat, the owner keeps the grant for a new burst regardless of other requests or priorities.
- R10: Once the lock strobe is low on the owner's final beat, normal arbitration resumes at that beat.
- R11: If no master is requesting on the final beat, the grant vector returns to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_MST | Request per master |
| prio | input | N_MST*PRIO_W | Priority per master, master i in bits [i*PRIO_W +: PRIO_W] |
| burst_len | input | N_MST*LEN_W | Fixed-burst beat count minus one, per master |
| burst_fixed | input | N_MST | Burst mode per master: 1 fixed, 0 variable |
| burst_term | input | N_MST | Variable-burst terminate strobe per master |
| lock | input | N_MST | Bus-lock strobe per master |
| xfer_done | input | 1 | One data beat completed this cycle |
| grant | output | N_MST | Registered one-hot grant |

## Verification
Every grant decision is registered once. The inputs that lead to a new grant, whether a request on an idle bus or the final beat of a burst, are sampled on one rising edge, and the new grant is due right after that same edge. The bench therefore drives each stimulus after a falling edge, lets one rising edge pass, and compares the grant at the next falling edge. Burst tests step beat by beat in this way, so the grant is checked to hold on every non-final beat and to move on exactly the cycle after the final one. The priority sweep decides on every cycle, because every burst there is one beat long. Its expected owner and round-robin pointer are computed arithmetically in the bench.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
// Package: shared burst-mode encoding for the arbiter.
// Assumes: mode bit 1 selects a counted burst, 0 a strobe-terminated one.
package arb_pkg;
    typedef enum logic {
        MODE_VAR   = 1'b0,
        MODE_FIXED = 1'b1
    } burst_mode_e;
endpackage

// File: rtl/arb_picker.sv
`timescale 1ns/1ps
// Module: arb_picker
// Combinational winner selection: highest priority value among requesters,
// ties broken by a rotating search starting at start_idx.
// Assumes: N_MST >= 2; prio is a flat vector, PRIO_W bits per master.
module arb_picker #(
    parameter int N_MST  = 4,
    parameter int PRIO_W = 2,
    localparam int IW    = $clog2(N_MST)
) (
    input  logic [N_MST-1:0]        req,
    input  logic [N_MST*PRIO_W-1:0] prio,
    input  logic [IW-1:0]           start_idx,
    output logic                    win_valid,
    output logic [IW-1:0]           win_idx
);
    logic [PRIO_W-1:0] top_prio;

    // Find the largest priority among requesting masters.
    always_comb begin
        top_prio = '0;
        for (int i = 0; i < N_MST; i++) begin
            if (req[i] && prio[i*PRIO_W +: PRIO_W] > top_prio)
                top_prio = prio[i*PRIO_W +: PRIO_W];
        end
    end

    // Rotating search for the first requester at the top priority.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int k = N_MST - 1; k >= 0; k--) begin
            int idx;
            idx = int'(start_idx) + k;
            if (idx >= N_MST) idx = idx - N_MST;
            if (req[idx] && prio[idx*PRIO_W +: PRIO_W] == top_prio) begin
                win_valid = 1'b1;
                win_idx   = IW'(idx);
            end
        end
    end

    // R3: a chosen winner is a requester
    always_comb begin
        if (win_valid) begin
            winner_req_chk: assert (req[win_idx]);
        end
    end
endmodule

// File: rtl/arb_beat_ctr.sv
`timescale 1ns/1ps
// Module: arb_beat_ctr
// Tracks beats of the current burst and flags the final beat.
// Assumes: load is pulsed on the edge a burst's grant is issued; beat is
// only meaningful while active.
module arb_beat_ctr
    import arb_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  burst_mode_e      load_mode,
    input  logic             active,
    input  logic             beat,
    input  logic             term,
    output logic             last
);
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    burst_mode_e      mode_q;

    // Final beat: count reached in fixed mode, terminate in variable mode.
    always_comb begin
        if (mode_q == MODE_FIXED)
            last = active && beat && (cnt_q == len_q);
        else
            last = active && beat && term;
    end

    // Capture burst parameters on load, count completed beats otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            len_q  <= '0;
            mode_q <= MODE_FIXED;
        end else if (load) begin
            cnt_q  <= '0;
            len_q  <= load_len;
            mode_q <= load_mode;
        end else if (active && beat) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R6
    beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mode_q == MODE_FIXED) |-> (cnt_q <= len_q));
endmodule

// File: rtl/prio_lock_arbiter.sv
`timescale 1ns/1ps
// Module: prio_lock_arbiter (top)
// Grants a shared bus to one of N_MST masters by run-time priority with
// round-robin tie-break, re-arbitrating on the final beat of each burst
// and honouring a lock that keeps the owner across bursts.
// Assumes: xfer_done marks one completed beat of the granted master.
module prio_lock_arbiter
    import arb_pkg::*;
#(
    parameter int N_MST  = 4,
    parameter int PRIO_W = 2,
    parameter int LEN_W  = 4,
    localparam int IW    = $clog2(N_MST)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_MST-1:0]        req,
    input  logic [N_MST*PRIO_W-1:0] prio,
    input  logic [N_MST*LEN_W-1:0]  burst_len,
    input  logic [N_MST-1:0]        burst_fixed,
    input  logic [N_MST-1:0]        burst_term,
    input  logic [N_MST-1:0]        lock,
    input  logic                    xfer_done,
    output logic [N_MST-1:0]        grant
);
    logic [N_MST-1:0] grant_q, grant_d;
    logic [IW-1:0]    ptr_q, owner_idx, load_idx, win_idx;
    logic             win_valid, owned, last, decide, keep, load, take_new;

    assign owned = |grant_q;
    assign grant = grant_q;

    // Encode the current owner's index from the one-hot grant.
    always_comb begin
        owner_idx = '0;
        for (int i = 0; i < N_MST; i++)
            if (grant_q[i]) owner_idx = IW'(i);
    end

    arb_picker #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_pick (
        .req       (req),
        .prio      (prio),
        .start_idx (ptr_q),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    arb_beat_ctr #(.LEN_W(LEN_W)) u_beat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_len  (burst_len[load_idx*LEN_W +: LEN_W]),
        .load_mode (burst_mode_e'(burst_fixed[load_idx])),
        .active    (owned),
        .beat      (xfer_done),
        .term      (burst_term[owner_idx]),
        .last      (last)
    );

    // Decision points: idle bus, or final beat of the current burst.
    assign decide   = !owned || last;
    assign keep     = owned && last && lock[owner_idx];
    assign take_new = decide && !keep && win_valid;

    // Next grant and burst-parameter load selection.
    always_comb begin
        grant_d  = grant_q;
        load     = 1'b0;
        load_idx = owner_idx;
        if (keep) begin
            load = 1'b1;
        end else if (take_new) begin
            grant_d  = '0;
            grant_d[win_idx] = 1'b1;
            load     = 1'b1;
            load_idx = win_idx;
        end else if (decide) begin
            grant_d = '0;
        end
    end

    // Register the grant and advance the round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            ptr_q   <= '0;
        end else begin
            grant_q <= grant_d;
            if (take_new)
                ptr_q <= (int'(win_idx) == N_MST - 1) ? '0 : win_idx + 1'b1;
        end
    end

    // R5
    onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));
    // R6
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && !last) |=> $stable(grant_q));
    // R9
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && last && lock[owner_idx]) |=> (grant_q == $past(grant_q)));
    // R2
    idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!owned && |req) |=> (grant_q != '0));
    // R11
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && last && !lock[owner_idx] && req == '0) |=> (grant_q == '0));
endmodule

// File: tb/sim_prio_lock_arbiter.sv
`timescale 1ns/1ps
// Bench: priority/round-robin sweep plus directed burst and lock cases.
module sim_prio_lock_arbiter;
    localparam int N = 4;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [7:0] prio = '0;
    logic [15:0] blen = '0;
    logic [3:0] bfix = '1;
    logic [3:0] bterm = '0;
    logic [3:0] lock = '0;
    logic       done = 1'b0;
    logic [3:0] grant;
    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    prio_lock_arbiter #(.N_MST(4), .PRIO_W(2), .LEN_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .prio(prio),
        .burst_len(blen), .burst_fixed(bfix), .burst_term(bterm),
        .lock(lock), .xfer_done(done), .grant(grant)
    );

    task automatic check(input logic [3:0] exp, input string tag);
        checks++;
        if (grant !== exp) begin
            errors++;
            $display("FAIL %s: grant=%b expected=%b", tag, grant, exp);
        end
    endtask

    // Drive xfer_done, pass one rising edge, compare at the falling edge.
    task automatic step(input logic d, input logic [3:0] exp, input string tag);
        done = d;
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: grant=%b expected=finish", grant);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ptr;
        ptr = 0;
        repeat (3) @(negedge clk);
        check(4'b0000, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(4'b0000, "R1 after reset");

        // Sweep: every request mask and priority set, one-beat bursts.
        for (int m = 1; m < 16; m++) begin
            for (int p = 0; p < 256; p++) begin
                int mx, ties, w;
                mx = -1; ties = 0; w = 0;
                for (int i = 0; i < N; i++)
                    if (m[i] && ((p >> (2*i)) & 3) > mx) mx = (p >> (2*i)) & 3;
                for (int i = 0; i < N; i++)
                    if (m[i] && ((p >> (2*i)) & 3) == mx) ties++;
                for (int k = N - 1; k >= 0; k--) begin
                    int idx;
                    idx = (ptr + k) % N;
                    if (m[idx] && ((p >> (2*idx)) & 3) == mx) w = idx;
                end
                req  = 4'(m);
                prio = 8'(p);
                step(1'b1, 4'(1 << w), ties > 1 ? "R4 tie rotate" : "R3 top prio");
                ptr = (w + 1) % N;
                checks++;
                if (!$onehot(grant)) begin
                    errors++;
                    $display("FAIL R5: grant=%b expected=one-hot", grant);
                end
            end
        end

        // R11: no requester on the final beat drops the grant.
        req = '0;
        step(1'b1, 4'b0000, "R11 release");
        prio = '0;

        // R6: master 1 fixed, 3 beats; done gaps do not count.
        req = 4'b0010; blen[7:4] = 4'd2;
        step(1'b0, 4'b0010, "R2 idle grant");
        req = 4'b0110; prio[5:4] = 2'd3; blen[11:8] = 4'd0;
        step(1'b1, 4'b0010, "R6 beat1");
        step(1'b0, 4'b0010, "R6 gap");
        step(1'b1, 4'b0010, "R6 beat2");
        step(1'b1, 4'b0100, "R8 handover");

        // R7: master 3 variable burst ending on terminate with done.
        req = 4'b1000; prio[7:6] = 2'd3; bfix[3] = 1'b0;
        step(1'b1, 4'b1000, "R8 handover");
        step(1'b1, 4'b1000, "R7 no term");
        step(1'b1, 4'b1000, "R7 no term");
        bterm[3] = 1'b1;
        step(1'b0, 4'b1000, "R7 term w/o done");
        req = 4'b0001; blen[3:0] = 4'd0;
        step(1'b1, 4'b0001, "R7 term end");
        bterm[3] = 1'b0;

        // R9 / R10: lock holds master 0 against a higher requester.
        lock[0] = 1'b1; req = 4'b0011; prio[3:2] = 2'd3; blen[7:4] = 4'd0;
        step(1'b1, 4'b0001, "R9 lock hold");
        step(1'b1, 4'b0001, "R9 lock hold");
        lock[0] = 1'b0;
        step(1'b1, 4'b0010, "R10 unlock");
        req = '0;
        step(1'b1, 4'b0000, "R11 release");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule